// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a SIMD integer datapath. It takes two packed source vectors and an accumulator vector. For each 32-bit lane it multiplies the narrow elements pairwise, adds the products of that lane at full precision, and adds the total to the signed 32-bit accumulator lane. Multiply, horizontal add and accumulate happen in one registered step. Feeding each result back in as the next accumulator builds up a long dot product, which is the core of an integer convolution or matrix-multiply loop.

There are two element formats, chosen by `mode`:

- **Byte mode** (`mode`=0): each lane holds four elements. Each unsigned byte of `src_a` multiplies the signed byte at the same position in `src_b`.
- **Word mode** (`mode`=1): each lane holds two elements. Each signed halfword of `src_a` multiplies the signed halfword at the same position in `src_b`.

When `sat_en` is set, a lane result that overflows is clamped to the signed 32-bit limits. When `sat_en` is clear, the result wraps.

The block is a one-stage pipeline with no state machine. Its only control state is the output-valid register. That register has two named conditions:

- **IDLE** (`out_valid`=0). It moves to **EMIT** on a cycle with `in_valid`.
- **EMIT** (`out_valid`=1). It stays in EMIT while `in_valid` remains high. It returns to IDLE on the first cycle without `in_valid`.

Top module: `dotacc_unit`

## Requirements
- R1: In byte mode, lane i of the result equals acc lane i plus the sum over k=0..3 of unsigned byte `src_a[32i+8k +: 8]` times signed byte `src_b[32i+8k +: 8]`. The products are summed at full precision, with no 16-bit clamping.
- R2: In word mode, lane i equals acc lane i plus the sum over j=0..1 of signed halfword `src_a[32i+16j +: 16]` times signed halfword `src_b[32i+16j +: 16]`, summed at full precision.
- R3: With `sat_en`=0, the lane result is the exact sum taken modulo 2^32 (two's-complement wrap).
- R4: With `sat_en`=1, an exact lane sum above 2^31-1 yields 0x7FFFFFFF.
- R5: With `sat_en`=1, an exact lane sum below -2^31 yields 0x80000000.
- R6: With `sat_en`=1, an exact lane sum inside the signed 32-bit range is returned unchanged.
- R7: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. `acc_out` carries that operation's result in that same cycle. Back-to-back operations are accepted every cycle.
- R8: A synchronous reset clears `out_valid` and `acc_out` to zero.
- R9: In a cycle without `in_valid`, `acc_out` keeps its previous value.
- R10: Each lane depends only on bits [32i+31:32i] of the three input vectors. There is no carry or clamp across lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 1 | 0 = byte (u8×s8), 1 = word (s16×s16) |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| src_a | input | 256 | First source vector (unsigned bytes or signed words) |
| src_b | input | 256 | Second source vector (signed bytes or signed words) |
| acc_in | input | 256 | Eight signed 32-bit accumulator lanes |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| acc_out | output | 256 | Eight updated signed 32-bit lanes |

## Verification
The assertions check on every cycle:

- the one-cycle valid relation;
- that `acc_out` holds when no operation is issued;
- that any saturated lane differs from its wrapped value only by being a signed limit of the correct sign;
- that byte-mode partial sums stay inside the u8×s8 bound.

Only the bench's scenarios can show that the arithmetic itself is right. To do that it compares every lane against a wide-integer model, using extreme operands (0, 255, -128, -32768), accumulators that overflow in both directions, back-to-back issue, and per-lane random data.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_WORD = 1'b1
    } dot_mode_e;

endpackage

// File: rtl/dotacc_mul.sv
module dotacc_mul
    import dotacc_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int DOT_W  = LANE_W + 2
) (
    input  logic [LANE_W-1:0]       a_i,
    input  logic [LANE_W-1:0]       b_i,
    input  dot_mode_e               mode_i,
    output logic signed [DOT_W-1:0] dot_o
);
    localparam int NB = LANE_W / 8;
    localparam int NW = LANE_W / 16;

    logic signed [16:0] bprod [NB];
    logic signed [31:0] wprod [NW];
    logic signed [DOT_W-1:0] bsum, wsum;

    // u8 x s8: widen both to 17-bit signed; the product always fits in 17 bits
    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic signed [16:0] ax, bx;
        assign ax       = 17'($signed({1'b0, a_i[8*k +: 8]}));
        assign bx       = 17'($signed(b_i[8*k +: 8]));
        assign bprod[k] = ax * bx;
    end

    // s16 x s16: the largest magnitude is 2^30, which fits in 32-bit signed
    for (genvar j = 0; j < NW; j++) begin : g_word
        logic signed [31:0] ax, bx;
        assign ax       = 32'($signed(a_i[16*j +: 16]));
        assign bx       = 32'($signed(b_i[16*j +: 16]));
        assign wprod[j] = ax * bx;
    end

    always_comb begin
        bsum = '0;
        wsum = '0;
        for (int k = 0; k < NB; k++) bsum = bsum + DOT_W'(bprod[k]);
        for (int j = 0; j < NW; j++) wsum = wsum + DOT_W'(wprod[j]);
    end

    always_comb begin
        unique case (mode_i)
            MODE_BYTE: dot_o = bsum;
            MODE_WORD: dot_o = wsum;
        endcase
    end

endmodule

// File: rtl/dotacc_lane.sv
module dotacc_lane
    import dotacc_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic [LANE_W-1:0] acc_i,
    input  dot_mode_e         mode_i,
    input  logic              sat_i,
    output logic [LANE_W-1:0] res_o
);
    localparam int DOT_W = LANE_W + 2;
    localparam int EX_W  = DOT_W + 1;
    localparam logic [LANE_W-1:0] LIM_HI = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] LIM_LO = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic signed [DOT_W-1:0] BYTE_BND = DOT_W'((LANE_W / 8) * 255 * 128);

    logic signed [DOT_W-1:0] dot;
    logic signed [EX_W-1:0]  exact;
    logic [EX_W-LANE_W:0]    upper;
    logic                    pos_ovf, neg_ovf;
    logic [LANE_W-1:0]       wrapped;

    dotacc_mul #(.LANE_W(LANE_W), .DOT_W(DOT_W)) u_mul (
        .a_i   (a_i),
        .b_i   (b_i),
        .mode_i(mode_i),
        .dot_o (dot)
    );

    assign exact   = EX_W'($signed(acc_i)) + EX_W'(dot);
    assign upper   = exact[EX_W-1:LANE_W-1];
    assign pos_ovf = !exact[EX_W-1] && (|upper);
    assign neg_ovf =  exact[EX_W-1] && !(&upper);
    assign wrapped = exact[LANE_W-1:0];

    always_comb begin
        if (sat_i && pos_ovf)      res_o = LIM_HI;
        else if (sat_i && neg_ovf) res_o = LIM_LO;
        else                       res_o = wrapped;
    end

    // R5: a clamped lane may only differ from the wrapped sum by landing on a limit
    p_clamp_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (res_o != wrapped) |-> (sat_i && (res_o == LIM_HI || res_o == LIM_LO)));

    // R4: a positive clamp only when the exact sum is non-negative
    p_clamp_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (res_o == LIM_HI && wrapped != LIM_HI) |-> !exact[EX_W-1]);

    // R1: byte-mode partial sum stays within four u8 x s8 products
    p_byte_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_BYTE) |-> (dot <= BYTE_BND && dot >= -BYTE_BND));

endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
    import dotacc_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      mode,
    input  logic                      sat_en,
    input  logic [LANES*LANE_W-1:0]   src_a,
    input  logic [LANES*LANE_W-1:0]   src_b,
    input  logic [LANES*LANE_W-1:0]   acc_in,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   acc_out
);
    localparam int VEC_W = LANES * LANE_W;

    dot_mode_e        mode_e;
    logic [VEC_W-1:0] lane_res;

    assign mode_e = dot_mode_e'(mode);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dotacc_lane #(.LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .a_i   (src_a [LANE_W*i +: LANE_W]),
            .b_i   (src_b [LANE_W*i +: LANE_W]),
            .acc_i (acc_in[LANE_W*i +: LANE_W]),
            .mode_i(mode_e),
            .sat_i (sat_en),
            .res_o (lane_res[LANE_W*i +: LANE_W])
        );
    end

    // valid register: IDLE (0) / EMIT (1)
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst)           acc_out <= '0;
        else if (in_valid) acc_out <= lane_res;
    end

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_out));

endmodule

// File: tb/dotacc_unit_bench.sv
`timescale 1ns/1ps
module dotacc_unit_bench;
    localparam int LANES = 8;
    localparam int LW    = 32;
    localparam int VW    = LANES * LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, mode = 1'b0, sat_en = 1'b0;
    logic [VW-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic out_valid;
    logic [VW-1:0] acc_out;

    int checks = 0;
    int fails  = 0;
    logic [VW-1:0] exp_q [$];
    string         tag_q [$];
    logic [VW-1:0] last_exp = '0;

    always #2 clk = ~clk;

    dotacc_unit u_dotacc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sat_en(sat_en),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] acc, input bit md, input bit sat);
        longint s = longint'($signed(acc));
        if (!md) begin
            for (int k = 0; k < 4; k++)
                s += longint'({1'b0, a[8*k +: 8]}) * longint'($signed(b[8*k +: 8]));
        end else begin
            for (int j = 0; j < 2; j++)
                s += longint'($signed(a[16*j +: 16])) * longint'($signed(b[16*j +: 16]));
        end
        if (sat && s > 64'sd2147483647)  s = 64'sd2147483647;
        if (sat && s < -64'sd2147483648) s = -64'sd2147483648;
        return s[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] acc,
                         input bit md, input bit sat, input string tag);
        logic [VW-1:0] e;
        for (int i = 0; i < LANES; i++)
            e[LW*i +: LW] = ref_lane(a[LW*i +: LW], b[LW*i +: LW], acc[LW*i +: LW], md, sat);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        @(negedge clk);
        src_a = a; src_b = b; acc_in = acc; mode = md; sat_en = sat; in_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = {8{32'hDEAD_BEEF}}; acc_in = {8{32'h1234_5678}};
    endtask

    // monitor: compares each result as it appears (R7 timing)
    always @(posedge clk) begin
        #1;
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", acc_out, '0);
            end else begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(acc_out === e, t, acc_out, e);
            end
        end
    end

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[LW*i +: LW] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid === 1'b0, "R8 out_valid", VW'(out_valid), '0);
        check(acc_out === '0, "R8 acc_out", acc_out, '0);
        rst = 1'b0;

        issue('0, '0, rnd_vec(), 1'b0, 1'b0, "R1 zero operands");
        issue({32{8'hFF}}, {32{8'h80}}, '0, 1'b0, 1'b0, "R1 255*-128");
        issue({32{8'hFF}}, {32{8'h7F}}, {8{32'd5}}, 1'b0, 1'b0, "R1 255*127");
        issue({16{16'h8000}}, {16{16'h8000}}, '0, 1'b1, 1'b0, "R3 word wrap to min");
        issue({16{16'h8000}}, {16{16'h8000}}, '0, 1'b1, 1'b1, "R4 word clamp high");
        issue({32{8'hFF}}, {32{8'h80}}, {8{32'h8000_0000}}, 1'b0, 1'b1, "R5 byte clamp low");
        issue({32{8'hFF}}, {32{8'h80}}, {8{32'h8000_0000}}, 1'b0, 1'b0, "R3 byte wrap negative");
        issue({32{8'hFF}}, {32{8'h7F}}, {8{32'h7FFF_FFF0}}, 1'b0, 1'b1, "R4 byte clamp high");
        issue({16{16'h7FFF}}, {16{16'h8000}}, {8{32'h8000_0000}}, 1'b1, 1'b1, "R5 word clamp low");
        issue({16{16'h7FFF}}, {16{16'h7FFF}}, {8{32'h1000}}, 1'b1, 1'b1, "R6 sat in range");
        issue({16{16'h8000}}, {16{16'h7FFF}}, '0, 1'b1, 1'b0, "R2 word min*max");
        // R10: mixed per-lane extremes, some lanes overflow and others do not
        issue({{4{32'hFFFF_FFFF}}, {4{32'h0}}}, {32{8'h80}},
              {32'h8000_0000, 32'h0, 32'h8000_0000, 32'h1, {4{32'h7FFF_FFFF}}}, 1'b0, 1'b1, "R10 lane isolation");
        for (int n = 0; n < 40; n++)
            issue(rnd_vec(), rnd_vec(), rnd_vec(), n[0], n[1], n[0] ? "R2 random word" : "R1 random byte");
        for (int n = 0; n < 10; n++)
            issue(rnd_vec(), rnd_vec(), {8{32'h0000_0100}}, n[0], 1'b1, "R6 random sat");
        idle();
        repeat (3) @(negedge clk);
        // R9 / R7: after idle inputs change, output holds and valid is low
        check(acc_out === last_exp, "R9 hold while idle", acc_out, last_exp);
        check(out_valid === 1'b0, "R7 valid drops", VW'(out_valid), '0);
        check(exp_q.size() == 0, "R7 every op produced one result", VW'(exp_q.size()), '0);
        // R8: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(acc_out === '0, "R8 reset clears result", acc_out, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule